// File: doc/BRIEF.md
# Serial Memory Slave Front End with Pause Gating

This block is the bit-level front end of a serial memory slave that talks a four-wire, mode-0 serial protocol (clock idle low, data captured on the rising clock edge, output updated on the falling edge, most significant bit first). It brings the select, serial clock, serial data in and pause pins into the system clock domain. It assembles received bits into bytes and hands each completed byte to the memory core with a one-cycle strobe. It shifts a core-supplied byte back out on the serial output with a separate output enable for tri-stating.

An active-low pause pin lets the host suspend a transfer in the middle of a byte without deselecting the device. While paused, the output is tri-stated and clock and data activity on the pins is ignored. The bit position, the received partial byte and the outgoing shift state are all frozen, so the transfer continues at the exact bit where it stopped. Pause entry and exit only take effect while the serial clock is low. If the clock is high, the change waits until the clock falls. Deselecting the device while paused discards the whole transfer state. The core's busy flag is an input: a running internal write or erase is never paused, and the block only asks the core to stall its command-level timing when the core is idle.

The controller has five states. ST_IDLE: deselected, or selected with pause low. ST_ACTIVE: normal shifting. ST_ENTER_WAIT: pause has fallen while the clock is high, and shifting continues. ST_HELD: paused. ST_LEAVE_WAIT: pause has risen while the clock is high, and the block is still paused.

The transitions are as follows:
- Select high from any state goes to ST_IDLE.
- ST_IDLE goes to ST_ACTIVE when select is low and pause is high.
- ST_ACTIVE goes to ST_HELD when pause is low and the clock is low, or to ST_ENTER_WAIT when pause is low and the clock is high.
- ST_ENTER_WAIT goes to ST_HELD once the clock is low, or back to ST_ACTIVE if pause returns high.
- ST_HELD goes to ST_ACTIVE when pause is high and the clock is low, or to ST_LEAVE_WAIT when pause is high and the clock is high.
- ST_LEAVE_WAIT goes to ST_ACTIVE once the clock is low, or back to ST_HELD if pause falls again.

Top module: `spi_pause_front`

## Requirements
- R1: With select low and not paused, each rising serial clock edge shifts the data-in level into the received byte, MSB first. After every 8 such edges, `rx_byte` holds the byte and `byte_valid` is high for exactly one system clock cycle.
- R2: `ser_dout` presents bit 7 of `tx_data` before the first rising edge of a selection. It advances by one bit (MSB first) on each falling edge. After the falling edge that follows the 8th rising edge of a byte, it reloads from `tx_data`.
- R3: When the pause pin falls while select is low and the clock is low, `pause_active` goes high and `ser_dout_en` goes low.
- R4: When the pause pin falls while the clock is high, `pause_active` stays low and the output stays enabled until the clock falls. That falling edge still completes its bit, and then the pause takes effect.
- R5: While paused, serial clock edges and data-in changes neither count bits nor produce `byte_valid`. A partial byte received before the pause is completed correctly by the bits sent after it.
- R6: When the pause pin rises while the clock is low, `pause_active` clears and `ser_dout_en` returns. If the clock is high at that time, `pause_active` stays high until the clock falls, and that falling edge is ignored.
- R7: Raising select while paused clears `pause_active`, the bit counter and both shift registers. `ser_dout_en` goes low.
- R8: After select is raised, shifting resumes only when select is low and the pause pin is high. With select low and pause low, the output stays disabled.
- R9: Raising select with no pause in effect disables the output and clears the bit counter. The next selection starts a fresh byte.
- R10: `stall_req` is high only while paused and `core_busy` is low. While `core_busy` is high, `stall_req` stays low even though the pause remains in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_pin | input | 1 | Active-low device select from the pin |
| ser_clk_pin | input | 1 | Serial clock from the pin |
| ser_din_pin | input | 1 | Serial data in from the pin |
| pause_n_pin | input | 1 | Active-low pause request from the pin |
| core_busy | input | 1 | Core is running an internal write or erase |
| tx_data | input | 8 | Byte the core wants shifted out next |
| ser_dout | output | 1 | Serial data out |
| ser_dout_en | output | 1 | Output enable for the serial data out driver |
| rx_byte | output | 8 | Last completed received byte |
| byte_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |
| pause_active | output | 1 | Pause condition in effect |
| stall_req | output | 1 | Request to the idle core to freeze its command timing |

## Verification
The delicate coincidence is a pause request that arrives in the same cycles as the serial clock falling edge that finishes a bit. With a deferred entry, that edge must both advance the outgoing shift register and move the controller into the held state. With a deferred exit, the edge must be swallowed while the controller leaves the held state. The bench provokes both by changing the pause pin while the clock is high, then lowering the clock. It judges the result by the output bits checked before each later rising edge and by the received byte that the scoreboard expects when the transfer completes.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ACTIVE     = 3'd1,
        ST_ENTER_WAIT = 3'd2,
        ST_HELD       = 3'd3,
        ST_LEAVE_WAIT = 3'd4
    } pause_state_t;

    // bit positions inside the synchronizer vector
    localparam int unsigned PIN_SEL   = 0;
    localparam int unsigned PIN_SCLK  = 1;
    localparam int unsigned PIN_DIN   = 2;
    localparam int unsigned PIN_PAUSE = 3;
    localparam int unsigned PIN_COUNT = 4;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= INIT;
        end else begin
            chain[0] <= async_in;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= INIT;
                end else begin
                    chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/spi_pause_fsm.sv
module spi_pause_fsm
    import spi_pause_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_s,
    input  logic         sclk_s,
    input  logic         pause_s,
    input  logic         core_busy,
    output pause_state_t state,
    output logic         shift_en,
    output logic         clear,
    output logic         dout_en,
    output logic         paused,
    output logic         stall_req
);

    pause_state_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        if (sel_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pause_s) nxt = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (!pause_s) nxt = sclk_s ? ST_ENTER_WAIT : ST_HELD;
                end
                ST_ENTER_WAIT: begin
                    if (pause_s)      nxt = ST_ACTIVE;
                    else if (!sclk_s) nxt = ST_HELD;
                end
                ST_HELD: begin
                    if (pause_s) nxt = sclk_s ? ST_LEAVE_WAIT : ST_ACTIVE;
                end
                ST_LEAVE_WAIT: begin
                    if (!pause_s)     nxt = ST_HELD;
                    else if (!sclk_s) nxt = ST_ACTIVE;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the current state
    always_comb begin
        shift_en  = 1'b0;
        clear     = 1'b0;
        dout_en   = 1'b0;
        paused    = 1'b0;
        stall_req = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clear = 1'b1;
            end
            ST_ACTIVE, ST_ENTER_WAIT: begin
                shift_en = 1'b1;
                dout_en  = 1'b1;
            end
            ST_HELD, ST_LEAVE_WAIT: begin
                paused    = 1'b1;
                stall_req = !core_busy;
            end
            default: begin
                clear = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              shift_en,
    input  logic              clear,
    input  logic [DATA_W-1:0] tx_data,
    output logic              dout,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_valid
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic              sclk_prev;
    logic              rise;
    logic              fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_next;

    assign rise    = sclk_s & ~sclk_prev;
    assign fall    = ~sclk_s & sclk_prev;
    assign rx_next = {rx_sh[DATA_W-2:0], din_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
                tx_sh   <= tx_data;
            end else if (shift_en) begin
                if (rise) begin
                    rx_sh <= rx_next;
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt    <= '0;
                        rx_byte    <= rx_next;
                        byte_valid <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else if (fall) begin
                    if (bit_cnt == '0) begin
                        tx_sh <= tx_data;
                    end else begin
                        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign dout = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_pause_front.sv
module spi_pause_front
    import spi_pause_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_pin,
    input  logic              ser_clk_pin,
    input  logic              ser_din_pin,
    input  logic              pause_n_pin,
    input  logic              core_busy,
    input  logic [DATA_W-1:0] tx_data,
    output logic              ser_dout,
    output logic              ser_dout_en,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              pause_active,
    output logic              stall_req
);

    localparam logic [PIN_COUNT-1:0] PIN_INIT = PIN_COUNT'(
        (1 << PIN_SEL) | (1 << PIN_PAUSE));

    logic [PIN_COUNT-1:0] pins_raw;
    logic [PIN_COUNT-1:0] pins_s;
    logic                 sel_s;
    logic                 sclk_s;
    logic                 din_s;
    logic                 pause_s;
    pause_state_t         fsm_state;
    logic                 shift_en;
    logic                 clear;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_SEL]   = sel_n_pin;
        pins_raw[PIN_SCLK]  = ser_clk_pin;
        pins_raw[PIN_DIN]   = ser_din_pin;
        pins_raw[PIN_PAUSE] = pause_n_pin;
    end

    spi_pin_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .INIT   (PIN_INIT)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    assign sel_s   = pins_s[PIN_SEL];
    assign sclk_s  = pins_s[PIN_SCLK];
    assign din_s   = pins_s[PIN_DIN];
    assign pause_s = pins_s[PIN_PAUSE];

    spi_pause_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (sel_s),
        .sclk_s    (sclk_s),
        .pause_s   (pause_s),
        .core_busy (core_busy),
        .state     (fsm_state),
        .shift_en  (shift_en),
        .clear     (clear),
        .dout_en   (ser_dout_en),
        .paused    (pause_active),
        .stall_req (stall_req)
    );

    spi_shift_unit #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .din_s      (din_s),
        .shift_en   (shift_en),
        .clear      (clear),
        .tx_data    (tx_data),
        .dout       (ser_dout),
        .rx_byte    (rx_byte),
        .byte_valid (byte_valid)
    );

endmodule

// File: rtl/spi_pause_chk.sv
module spi_pause_chk
    import spi_pause_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         sel_s,
    input logic         sclk_s,
    input logic         pause_s,
    input pause_state_t fsm_state,
    input logic         core_busy,
    input logic         ser_dout_en,
    input logic         byte_valid,
    input logic         pause_active,
    input logic         stall_req
);

    // R3: output is never driven while paused
    p_tristate_in_pause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pause_active |-> !ser_dout_en);

    // R4: a pause seen with the clock high does not take hold at once
    p_deferred_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ACTIVE && !sel_s && !pause_s && sclk_s) |=> !pause_active);

    // R5: no byte completes while paused
    p_no_byte_in_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pause_active |-> !byte_valid);

    // R1: the byte strobe is a single-cycle pulse
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R7 / R9: deselect drops the output enable and the pause flag
    p_deselect_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (!ser_dout_en && !pause_active));

    // R10: stall only while paused and the core is idle
    p_stall_idle_core_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (pause_active && !core_busy));

endmodule

bind spi_pause_front spi_pause_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_s        (sel_s),
    .sclk_s       (sclk_s),
    .pause_s      (pause_s),
    .fsm_state    (fsm_state),
    .core_busy    (core_busy),
    .ser_dout_en  (ser_dout_en),
    .byte_valid   (byte_valid),
    .pause_active (pause_active),
    .stall_req    (stall_req)
);

// File: tb/tb_spi_pause_front.sv
`timescale 1ns/1ps
module tb_spi_pause_front;

    localparam int HALF = 6;  // serial half period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n_pin = 1'b1;
    logic       ser_clk_pin = 1'b0;
    logic       ser_din_pin = 1'b0;
    logic       pause_n_pin = 1'b1;
    logic       core_busy = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       ser_dout;
    logic       ser_dout_en;
    logic [7:0] rx_byte;
    logic       byte_valid;
    logic       pause_active;
    logic       stall_req;

    int n_cmp = 0, n_bad = 0;
    int m_cmp = 0, m_bad = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;  // 250 MHz

    spi_pause_front dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n_pin    (sel_n_pin),
        .ser_clk_pin  (ser_clk_pin),
        .ser_din_pin  (ser_din_pin),
        .pause_n_pin  (pause_n_pin),
        .core_busy    (core_busy),
        .tx_data      (tx_data),
        .ser_dout     (ser_dout),
        .ser_dout_en  (ser_dout_en),
        .rx_byte      (rx_byte),
        .byte_valid   (byte_valid),
        .pause_active (pause_active),
        .stall_req    (stall_req)
    );

    // scoreboard monitor: every strobe pops one expected byte (R1, R5)
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            m_cmp++;
            if (exp_q.size() == 0) begin
                m_bad++;
                $display("FAIL R1/R5 unexpected byte: actual %02h expected none", rx_byte);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rx_byte !== e) begin
                    m_bad++;
                    $display("FAIL R1 rx_byte: actual %02h expected %02h", rx_byte, e);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one serial bit: drive data, check output bit, pulse the clock
    task automatic shift_bit(input logic b, input logic so_exp, input string req);
        ser_din_pin = b;
        wait_clk(HALF);
        check(req, {7'd0, ser_dout}, {7'd0, so_exp});
        ser_clk_pin = 1'b1;
        wait_clk(HALF);
        ser_clk_pin = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] rx, input logic [7:0] tx,
                             input int hi, input int lo);
        for (int i = hi; i >= lo; i--) shift_bit(rx[i], tx[i], "R2 ser_dout");
    endtask

    task automatic send_byte(input logic [7:0] rx, input logic [7:0] tx);
        exp_q.push_back(rx);
        send_bits(rx, tx, 7, 0);
    endtask

    task automatic select(input logic v);
        sel_n_pin = v;
        wait_clk(HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 n_cmp + m_cmp + 1, n_bad + m_bad + 1);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // reset state
        check("R9 reset oe", {7'd0, ser_dout_en}, 8'd0);
        check("R3 reset pause", {7'd0, pause_active}, 8'd0);
        check("R10 reset stall", {7'd0, stall_req}, 8'd0);

        // R1 R2: one byte
        tx_data = 8'hA5;
        select(1'b0);
        check("R9 oe on select", {7'd0, ser_dout_en}, 8'd1);
        send_byte(8'h3C, 8'hA5);
        wait_clk(HALF);
        select(1'b1);

        // R1 R2: back-to-back bytes, output reloads per byte
        tx_data = 8'h96;
        select(1'b0);
        send_byte(8'hC3, 8'h96);
        send_byte(8'h5A, 8'h96);
        wait_clk(HALF);
        select(1'b1);

        // R3 R5 R6 R10: pause mid-byte with clock low
        tx_data = 8'hA5;
        select(1'b0);
        exp_q.push_back(8'h6B);
        send_bits(8'h6B, 8'hA5, 7, 5);
        wait_clk(HALF);
        pause_n_pin = 1'b0;
        wait_clk(HALF);
        check("R3 pause_active", {7'd0, pause_active}, 8'd1);
        check("R3 oe off", {7'd0, ser_dout_en}, 8'd0);
        check("R10 stall idle core", {7'd0, stall_req}, 8'd1);
        for (int k = 0; k < 4; k++) begin
            ser_din_pin = k[0];
            ser_clk_pin = 1'b1;
            wait_clk(HALF);
            ser_clk_pin = 1'b0;
            wait_clk(HALF);
        end
        core_busy = 1'b1;
        wait_clk(4);
        check("R10 no stall busy", {7'd0, stall_req}, 8'd0);
        check("R10 still paused", {7'd0, pause_active}, 8'd1);
        core_busy = 1'b0;
        pause_n_pin = 1'b1;
        wait_clk(HALF);
        check("R6 exit pause", {7'd0, pause_active}, 8'd0);
        check("R6 oe back", {7'd0, ser_dout_en}, 8'd1);
        send_bits(8'h6B, 8'hA5, 4, 0);
        wait_clk(HALF);
        select(1'b1);

        // R4 R6: deferred entry and deferred exit
        tx_data = 8'h3C;
        select(1'b0);
        exp_q.push_back(8'h81);
        send_bits(8'h81, 8'h3C, 7, 6);
        ser_din_pin = 1'b0;
        wait_clk(HALF);
        check("R2 ser_dout", {7'd0, ser_dout}, 8'd1);
        ser_clk_pin = 1'b1;
        wait_clk(HALF);
        pause_n_pin = 1'b0;
        wait_clk(HALF);
        check("R4 entry deferred", {7'd0, pause_active}, 8'd0);
        check("R4 oe kept", {7'd0, ser_dout_en}, 8'd1);
        ser_clk_pin = 1'b0;
        wait_clk(HALF);
        check("R4 entry on low", {7'd0, pause_active}, 8'd1);
        ser_din_pin = 1'b1;
        ser_clk_pin = 1'b1;
        wait_clk(HALF);
        pause_n_pin = 1'b1;
        wait_clk(HALF);
        check("R6 exit deferred", {7'd0, pause_active}, 8'd1);
        ser_clk_pin = 1'b0;
        wait_clk(HALF);
        check("R6 exit on low", {7'd0, pause_active}, 8'd0);
        send_bits(8'h81, 8'h3C, 4, 0);
        wait_clk(HALF);
        select(1'b1);

        // R7 R8: deselect during pause resets the transfer
        tx_data = 8'h5A;
        select(1'b0);
        send_bits(8'hFF, 8'h5A, 7, 5);
        wait_clk(HALF);
        pause_n_pin = 1'b0;
        wait_clk(HALF);
        select(1'b1);
        check("R7 pause cleared", {7'd0, pause_active}, 8'd0);
        check("R7 oe off", {7'd0, ser_dout_en}, 8'd0);
        select(1'b0);
        check("R8 no restart paused", {7'd0, ser_dout_en}, 8'd0);
        check("R8 not paused", {7'd0, pause_active}, 8'd0);
        pause_n_pin = 1'b1;
        wait_clk(HALF);
        check("R8 restart", {7'd0, ser_dout_en}, 8'd1);
        send_byte(8'h24, 8'h5A);  // R7 fresh counter and shift state
        wait_clk(HALF);
        select(1'b1);

        // R9: deselect mid-byte without pause
        tx_data = 8'hC6;
        select(1'b0);
        send_bits(8'h00, 8'hC6, 7, 4);
        wait_clk(HALF);
        select(1'b1);
        check("R9 oe off", {7'd0, ser_dout_en}, 8'd0);
        select(1'b0);
        send_byte(8'hE7, 8'hC6);
        wait_clk(HALF);
        select(1'b1);
        wait_clk(8);

        check("R1 queue drained", 8'(exp_q.size()), 8'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 n_cmp + m_cmp, n_bad + m_bad);
        $finish;
    end

endmodule